// File: doc/BRIEF.md
# Predictive Per-Leg Voltage Reference Generator

This block sits in the current loop of a two-leg, three-level rectifier. On each sample strobe it captures the sampled line voltage, line current and current reference, together with the leg states that were applied in the present period and the measured dc-link voltage. From these it works out the voltage that each leg should produce one sample ahead, so that the line current reaches its reference after one period of computation delay.

Internally it keeps a three-deep history of the current reference and of the line voltage. It predicts the line current at the next sample from the plant model (series resistance and inductance over one sample period) and the applied line voltage. It extrapolates the reference current two samples ahead and the line voltage one sample ahead. It then solves the deadbeat equation for the line-to-line voltage and splits that voltage into two leg references of equal size and opposite sign. All model constants are signed fixed-point parameters with `CF` fractional bits. Every intermediate result is clipped to the signed `W`-bit range.

Top module: `diff_ref_gen`

## Requirements
- R1: While `rst_n` is low, both leg references are 0 and `done` is low. After reset, all history entries are zero, so the first computation treats every earlier sample as 0.
- R2: A strobe is accepted only when no computation is in flight, which means a new strobe is possible from the fifth edge after an accepted strobe. A strobe raised while a computation is running is ignored: it shifts no history and starts nothing, and later results do not depend on the inputs present at that time.
- R3: The current reference is extrapolated one step as e1 = clip(3·r(k) − 3·r(k−1) + r(k−2)), and two steps as e2 = clip(3·e1 − 3·r(k) + r(k−1)). Here r(k) is the value captured at the present strobe.
- R4: The line voltage one step ahead is estimated as clip(3·v(k) − 3·v(k−1) + v(k−2)) from the captured line-voltage history.
- R5: The applied line voltage is vab = clip(la − lb). Each leg contributes (vdcIn >>> 1) for state code 2'b01, −(vdcIn >>> 1) for code 2'b11, and 0 for codes 2'b00 and 2'b10. The predicted current is ip = clip((KCUR·i(k) + KDRIVE·clip(v(k) − vab)) >>> CF).
- R6: `vRefA` = clip(vp − clip((KRES·ip) >>> CF) − clip((KIND·clip(e2 − ip)) >>> CF)) >>> 1, where vp is the R4 estimate. The halving is an arithmetic right shift, so `vRefA` stays within [−2^(W−2), 2^(W−2)−1].
- R7: `vRefB` is always the exact two's-complement negative of `vRefA`.
- R8: Every intermediate named in R3–R6 saturates to [−2^(W−1), 2^(W−1)−1] instead of wrapping.
- R9: `done` is a one-cycle pulse that is high in the cycle after the fourth rising edge following the edge that accepted the strobe. The leg references change only at that same edge and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Sample strobe; starts a computation when idle |
| vsIn | input | W | Sampled line voltage, signed |
| isIn | input | W | Sampled line current, signed |
| iRefIn | input | W | Current reference sample, signed |
| legStateA | input | 2 | Applied state of leg a (01 = +, 11 = −, 00/10 = 0) |
| legStateB | input | 2 | Applied state of leg b, same coding |
| vdcIn | input | W | Measured dc-link voltage, signed |
| vRefA | output | W | Leg-a voltage reference for the next sample |
| vRefB | output | W | Leg-b voltage reference, negative of leg a |
| done | output | 1 | One-cycle pulse when new references are valid |

## Verification
Some properties are checked on every cycle: at most one stage is active at a time, a strobe raised while busy never starts a stage, the history registers move only on an accepted strobe, the outputs hold except at the final stage, `vRefA` stays in the halved range, and `done` never lasts two cycles. Other behaviour can only be shown by the bench scenarios, because it depends on arithmetic across several samples. This covers the exact extrapolated and predicted values, the saturation of each intermediate when inputs sit at the rails, the leg-state decoding including the unused code, and the fact that a strobe ignored while busy leaves later results untouched. The bench compares every result against a model written from R3–R6 over directed ramps, rail values and seeded random samples.

// File: rtl/drg_pkg.sv
package drg_pkg;

  // Stage strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic load;  // accepted sample strobe: capture and shift history
    logic st1;   // extrapolate reference and voltage, predict current
    logic st2;   // second-step reference extrapolation
    logic st3;   // resistive drop and inductive slope
    logic st4;   // final reference, halve and mirror
  } stage_t;

  // Applied leg state coding (R5)
  typedef enum logic [1:0] {
    LEG_ZERO = 2'b00,
    LEG_POS  = 2'b01,
    LEG_RSVD = 2'b10,
    LEG_NEG  = 2'b11
  } leg_t;

endpackage

// File: rtl/drg_ctrl.sv
module drg_ctrl
  import drg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sampleStb,
  output stage_t stages,
  output logic   done
);

  localparam int STAGES = 4;

  logic [STAGES-1:0] pipe;
  logic              busy;
  logic              accept;

  assign busy   = |pipe;
  assign accept = sampleStb && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
      done <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], accept};
      done <= pipe[STAGES-1];
    end
  end

  always_comb begin
    stages.load = accept;
    stages.st1  = pipe[0];
    stages.st2  = pipe[1];
    stages.st3  = pipe[2];
    stages.st4  = pipe[3];
  end

  // R2: only one computation in flight
  assert_single_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pipe));

  // R2: a strobe seen while busy does not launch a stage
  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && busy) |=> !pipe[0]);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/drg_datapath.sv
module drg_datapath
  import drg_pkg::*;
#(
  parameter int W      = 16,
  parameter int CF     = 12,
  parameter int KCUR   = 4092,
  parameter int KDRIVE = 41,
  parameter int KRES   = 410,
  parameter int KIND   = 409600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stage_t              stages,
  input  logic signed [W-1:0] vsIn,
  input  logic signed [W-1:0] isIn,
  input  logic signed [W-1:0] iRefIn,
  input  logic [1:0]          legStateA,
  input  logic [1:0]          legStateB,
  input  logic signed [W-1:0] vdcIn,
  output logic signed [W-1:0] vRefA,
  output logic signed [W-1:0] vRefB
);

  localparam logic signed [63:0] MAXV = (64'sd1 <<< (W-1)) - 64'sd1;
  localparam logic signed [63:0] MINV = -(64'sd1 <<< (W-1));
  localparam logic signed [W-1:0] HALF_MAX = W'((64'sd1 <<< (W-2)) - 64'sd1);
  localparam logic signed [W-1:0] HALF_MIN = W'(-(64'sd1 <<< (W-2)));
  localparam logic signed [63:0] K_CUR   = 64'(KCUR);
  localparam logic signed [63:0] K_DRIVE = 64'(KDRIVE);
  localparam logic signed [63:0] K_RES   = 64'(KRES);
  localparam logic signed [63:0] K_IND   = 64'(KIND);

  function automatic logic signed [W-1:0] clip(input logic signed [63:0] x);
    if (x > MAXV)      return MAXV[W-1:0];
    else if (x < MINV) return MINV[W-1:0];
    else               return x[W-1:0];
  endfunction

  function automatic logic signed [63:0] wide(input logic signed [W-1:0] x);
    return 64'(x);
  endfunction

  function automatic logic signed [W-1:0] extrap(input logic signed [W-1:0] x0,
                                                  input logic signed [W-1:0] x1,
                                                  input logic signed [W-1:0] x2);
    return clip(64'sd3 * wide(x0) - 64'sd3 * wide(x1) + wide(x2));
  endfunction

  function automatic logic signed [63:0] legVolt(input logic [1:0] code,
                                                 input logic signed [63:0] half);
    case (leg_t'(code))
      LEG_POS: return half;
      LEG_NEG: return -half;
      default: return 64'sd0;
    endcase
  endfunction

  // Sample histories: index 0 is the newest (k), 2 the oldest (k-2)
  logic signed [W-1:0] vsHist [3];
  logic signed [W-1:0] irHist [3];
  logic signed [W-1:0] isNow;
  logic signed [W-1:0] vabNow;

  // Stage results
  logic signed [W-1:0] irNext1;
  logic signed [W-1:0] irNext2;
  logic signed [W-1:0] vsNext;
  logic signed [W-1:0] isNext;
  logic signed [W-1:0] dropR;
  logic signed [W-1:0] slopeR;

  // Combinational helpers
  logic signed [63:0]  halfDc;
  logic signed [W-1:0] vabIn;
  logic signed [W-1:0] drive;
  logic signed [W-1:0] trackErr;
  logic signed [W-1:0] lineRef;

  always_comb begin
    halfDc   = wide(vdcIn) >>> 1;
    vabIn    = clip(legVolt(legStateA, halfDc) - legVolt(legStateB, halfDc));
    drive    = clip(wide(vsHist[0]) - wide(vabNow));
    trackErr = clip(wide(irNext2) - wide(isNext));
    lineRef  = clip(wide(vsNext) - wide(dropR) - wide(slopeR));
  end

  // History shift registers, one per sampled channel
  for (genvar g = 0; g < 3; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vsHist[g] <= '0;
        irHist[g] <= '0;
      end else if (stages.load) begin
        vsHist[g] <= (g == 0) ? vsIn   : vsHist[(g == 0) ? 0 : g-1];
        irHist[g] <= (g == 0) ? iRefIn : irHist[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isNow   <= '0;
      vabNow  <= '0;
      irNext1 <= '0;
      irNext2 <= '0;
      vsNext  <= '0;
      isNext  <= '0;
      dropR   <= '0;
      slopeR  <= '0;
      vRefA   <= '0;
      vRefB   <= '0;
    end else begin
      if (stages.load) begin
        isNow  <= isIn;
        vabNow <= vabIn;
      end
      if (stages.st1) begin
        irNext1 <= extrap(irHist[0], irHist[1], irHist[2]);
        vsNext  <= extrap(vsHist[0], vsHist[1], vsHist[2]);
        isNext  <= clip((K_CUR * wide(isNow) + K_DRIVE * wide(drive)) >>> CF);
      end
      if (stages.st2) begin
        irNext2 <= extrap(irNext1, irHist[0], irHist[1]);
      end
      if (stages.st3) begin
        dropR  <= clip((K_RES * wide(isNext)) >>> CF);
        slopeR <= clip((K_IND * wide(trackErr)) >>> CF);
      end
      if (stages.st4) begin
        vRefA <= lineRef >>> 1;
        vRefB <= -(lineRef >>> 1);
      end
    end
  end

  // R2: histories move only on an accepted strobe
  assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stages.load |=> ($stable(vsHist[0]) && $stable(irHist[0]) && $stable(vsHist[2])));

  // R9: outputs change only at the final stage
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stages.st4 |=> ($stable(vRefA) && $stable(vRefB)));

  // R6: leg reference stays within the halved range
  assert_half_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vRefA >= HALF_MIN) && (vRefA <= HALF_MAX));

endmodule

// File: rtl/diff_ref_gen.sv
module diff_ref_gen
  import drg_pkg::*;
#(
  parameter int W      = 16,
  parameter int CF     = 12,
  parameter int KCUR   = 4092,
  parameter int KDRIVE = 41,
  parameter int KRES   = 410,
  parameter int KIND   = 409600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleStb,
  input  logic signed [W-1:0] vsIn,
  input  logic signed [W-1:0] isIn,
  input  logic signed [W-1:0] iRefIn,
  input  logic [1:0]          legStateA,
  input  logic [1:0]          legStateB,
  input  logic signed [W-1:0] vdcIn,
  output logic signed [W-1:0] vRefA,
  output logic signed [W-1:0] vRefB,
  output logic                done
);

  stage_t stages;

  drg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampleStb (sampleStb),
    .stages    (stages),
    .done      (done)
  );

  drg_datapath #(
    .W(W), .CF(CF), .KCUR(KCUR), .KDRIVE(KDRIVE), .KRES(KRES), .KIND(KIND)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stages    (stages),
    .vsIn      (vsIn),
    .isIn      (isIn),
    .iRefIn    (iRefIn),
    .legStateA (legStateA),
    .legStateB (legStateB),
    .vdcIn     (vdcIn),
    .vRefA     (vRefA),
    .vRefB     (vRefB)
  );

endmodule

// File: tb/sim_diff_ref_gen.sv
module sim_diff_ref_gen;

  localparam int     W      = 16;
  localparam int     CF     = 12;
  localparam longint KCUR   = 4092;
  localparam longint KDRIVE = 41;
  localparam longint KRES   = 410;
  localparam longint KIND   = 409600;
  localparam longint MAXV   = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV   = -(64'sd1 <<< (W-1));

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic                sampleStb;
  logic signed [W-1:0] vsIn, isIn, iRefIn, vdcIn;
  logic [1:0]          legStateA, legStateB;
  logic signed [W-1:0] vRefA, vRefB;
  logic                done;

  diff_ref_gen u0 (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb),
    .vsIn(vsIn), .isIn(isIn), .iRefIn(iRefIn),
    .legStateA(legStateA), .legStateB(legStateB), .vdcIn(vdcIn),
    .vRefA(vRefA), .vRefB(vRefB), .done(done)
  );

  int     nCmp = 0;
  int     nBad = 0;
  longint mVs[3];
  longint mIr[3];

  function automatic longint sat(longint x);
    if (x > MAXV) return MAXV;
    if (x < MINV) return MINV;
    return x;
  endfunction

  function automatic longint legV(logic [1:0] s, longint half);
    if (s == 2'b01) return half;
    if (s == 2'b11) return -half;
    return 0;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample; poke raises a strobe while busy that must be ignored (R2)
  task automatic runSample(logic signed [W-1:0] vs, logic signed [W-1:0] is,
                           logic signed [W-1:0] ir, logic [1:0] la, logic [1:0] lb,
                           logic signed [W-1:0] vdc, bit poke);
    longint half, vab, ir1, ir2, vs1, dv, isp, drop, slope, ea;
    mVs[2] = mVs[1]; mVs[1] = mVs[0]; mVs[0] = longint'(vs);
    mIr[2] = mIr[1]; mIr[1] = mIr[0]; mIr[0] = longint'(ir);
    half  = longint'(vdc) >>> 1;
    vab   = sat(legV(la, half) - legV(lb, half));                 // R5
    ir1   = sat(3*mIr[0] - 3*mIr[1] + mIr[2]);                    // R3
    vs1   = sat(3*mVs[0] - 3*mVs[1] + mVs[2]);                    // R4
    dv    = sat(mVs[0] - vab);
    isp   = sat((KCUR*longint'(is) + KDRIVE*dv) >>> CF);          // R5
    ir2   = sat(3*ir1 - 3*mIr[0] + mIr[1]);                       // R3
    drop  = sat((KRES*isp) >>> CF);
    slope = sat((KIND*sat(ir2 - isp)) >>> CF);                    // R8
    ea    = sat(vs1 - drop - slope) >>> 1;                        // R6

    @(negedge clk);
    vsIn = vs; isIn = is; iRefIn = ir; legStateA = la; legStateB = lb; vdcIn = vdc;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    chk("R9 done early", longint'(done), 0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      if (i == 1 && poke) begin
        vsIn = 16'sh1234; isIn = -16'sd777; iRefIn = 16'sh2222;
        legStateA = 2'b11; legStateB = 2'b01; sampleStb = 1'b1;
      end else begin
        sampleStb = 1'b0;
      end
      chk("R9 done early", longint'(done), 0);
    end
    @(negedge clk);
    chk("R9 done pulse", longint'(done), 1);
    chk("R6 vRefA", longint'(vRefA), ea);
    chk("R7 vRefB", longint'(vRefB), -ea);
    @(negedge clk);
    chk("R9 done width", longint'(done), 0);
    chk("R9 vRefA hold", longint'(vRefA), ea);
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [1:0] codes[4];
    int unused;
    codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b10; codes[3] = 2'b11;
    for (int i = 0; i < 3; i++) begin mVs[i] = 0; mIr[i] = 0; end
    rst_n = 1'b0; sampleStb = 1'b0;
    vsIn = '0; isIn = '0; iRefIn = '0; vdcIn = '0; legStateA = '0; legStateB = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 vRefA reset", longint'(vRefA), 0);
    chk("R1 vRefB reset", longint'(vRefB), 0);
    chk("R1 done reset", longint'(done), 0);
    rst_n = 1'b1;

    // R1: first sample sees zero history; R5 leg coding 01/11
    runSample(16'sd1000, 16'sd100, 16'sd200, 2'b01, 2'b11, 16'sd2000, 1'b0);
    // R3/R4: linear ramps are extrapolated exactly
    runSample(16'sd1100, 16'sd120, 16'sd300, 2'b01, 2'b00, 16'sd2000, 1'b0);
    runSample(16'sd1200, 16'sd140, 16'sd400, 2'b00, 2'b11, 16'sd2000, 1'b0);
    // R5: unused code 10 acts as zero on both legs
    runSample(16'sd1300, -16'sd50, 16'sd500, 2'b10, 2'b10, 16'sd2400, 1'b0);
    // R2: strobe while busy is ignored
    runSample(16'sd900, 16'sd60, 16'sd450, 2'b11, 2'b01, 16'sd2400, 1'b1);
    runSample(16'sd800, 16'sd40, 16'sd420, 2'b01, 2'b01, 16'sd2400, 1'b1);
    // R8: rail inputs saturate intermediates
    runSample(16'sh7fff, 16'sh7fff, 16'sh7fff, 2'b11, 2'b01, 16'sh7fff, 1'b0);
    runSample(-16'sh8000, -16'sh8000, -16'sh8000, 2'b01, 2'b11, 16'sh7fff, 1'b0);
    runSample(16'sh7fff, -16'sh8000, 16'sh7fff, 2'b00, 2'b00, 16'sd0, 1'b0);

    unused = $urandom(32'd2024);
    for (int n = 0; n < 250; n++) begin
      logic signed [W-1:0] rv, ri, rr, rd;
      bit wide;
      wide = ($urandom % 8) == 0;
      rv = wide ? W'($urandom) : W'(int'($urandom % 16001) - 8000);
      ri = wide ? W'($urandom) : W'(int'($urandom % 2001) - 1000);
      rr = wide ? W'($urandom) : W'(int'($urandom % 2001) - 1000);
      rd = W'($urandom % 20000);
      runSample(rv, ri, rr, codes[$urandom % 4], codes[$urandom % 4], rd,
                ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule